// File: doc/BRIEF.md
# DDR Multi-Bank Command Legality Monitor

This block watches the command pins of a multi-bank DDR SDRAM controller. On every clock edge where clock enable is high, and was also high at the previous edge, it decodes the strobes into a command. It then judges that command against the state of the addressed bank and against what every other bank is doing. Each bank has its own sequencer. The sequencer follows row opening, bursts, explicit precharge and the two phases of an auto-precharge burst, using programmable cycle counts.

A command that passes the rules advances the addressed bank. A command that fails raises a one-cycle flag and leaves every bank as it was. The monitor drives nothing on the memory bus. It is intended for bus checkers, controller bring-up and on-chip protocol guards.

Top module: `ddr_bank_cmd_checker`

## Requirements
- R1: With cs_n high the command is Deselect (code 0). Otherwise {ras_n,cas_n,we_n} decodes as 111 NOP (1), 011 Activate (2), 101 Read (3), 100 Write (4), 010 Precharge (5), 001 Auto Refresh (6), 000 Mode Register Set (7) and 110 Burst Terminate (8). The code of an evaluated command appears on cmd_o one cycle after its edge.
- R2: Deselect and NOP are always legal and change no bank. Banks that have timed states keep counting.
- R3: Activate is legal only to a bank in Idle (state code 0). The bank then shows Opening (1) for T_RCD cycles and after that Row Active (2).
- R4: Read and Write to a bank are legal only when that bank is in Row Active, Read (3) or Write (4). A Write is not legal while that same bank is in Read. A Read enters Read and a Write enters Write. Each burst lasts BURST_LEN/2 cycles and the bank then returns to Row Active.
- R5: Precharge to a bank in Row Active, Read or Write is legal. The bank shows Closing (8) for T_RP cycles and then Idle. With PRE_IDLE_LEGAL set, Precharge to an Idle bank is legal and changes nothing. Precharge to a bank in any other state is illegal.
- R6: While another bank is in Read, a Write to any bank is illegal. A bank in Write blocks nothing elsewhere. A bank in Idle, Opening, Row Active or Closing blocks nothing elsewhere.
- R7: A Read with ap_i high enters Read-AP access (5) for BURST_LEN/2 cycles. A Write with ap_i high enters Write-AP access (6) for BURST_LEN/2+T_WR cycles. Both then show AP close (7) for T_RP cycles and then Idle.
- R8: While any other bank is in Read-AP access or Write-AP access, Read and Write are illegal, while Activate and Precharge stay legal. A bank in AP close blocks nothing elsewhere.
- R9: Auto Refresh and Mode Register Set are legal only when every bank is Idle, and they change no bank.
- R10: Burst Terminate is legal only to a bank in Read. That bank returns to Row Active on the next cycle.
- R11: An illegal command sets illegal_o for exactly the one cycle after its edge. It changes no bank state.
- R12: A command is evaluated only if cke_i is high at its edge and was high at the previous edge. Otherwise it is ignored: illegal_o stays low, cmd_o shows 0, and no bank state changes.
- R13: After reset every bank is Idle, illegal_o is low and cmd_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cke_i | input | 1 | Clock enable seen on the bus |
| cs_n_i | input | 1 | Chip select, active low |
| ras_n_i | input | 1 | Row strobe, active low |
| cas_n_i | input | 1 | Column strobe, active low |
| we_n_i | input | 1 | Write enable, active low |
| ba_i | input | $clog2(NUM_BANKS) | Bank address |
| ap_i | input | 1 | Auto-precharge request bit |
| illegal_o | output | 1 | One-cycle flag for a rejected command |
| cmd_o | output | 4 | Code of the evaluated command |
| bank_state_o | output | 4*NUM_BANKS | State code of each bank, bank 0 in the low nibble |

## Verification
A bank sequencer stuck in a wrong state shows up on bank_state_o one cycle after the edge that should have moved it. Later it also shows up as a wrong illegal_o on the first command that depends on that bank. For example, a Write elsewhere would be accepted during a Read that the monitor had already ended. An off-by-one in any cycle count moves the step between state codes by one cycle, and a cycle-by-cycle comparison against an arithmetic model catches it on the spot. Errors in the rule table show up only when a command meets the exact combination of states it mishandles, so the stimulus steers towards commands that are currently legal, which keeps bursts and auto-precharge phases busy.

// File: rtl/ddr_chk_pkg.sv
package ddr_chk_pkg;

   typedef enum logic [3:0] {
      CMD_DESEL = 4'd0,
      CMD_NOP   = 4'd1,
      CMD_ACT   = 4'd2,
      CMD_RD    = 4'd3,
      CMD_WR    = 4'd4,
      CMD_PRE   = 4'd5,
      CMD_REF   = 4'd6,
      CMD_MRS   = 4'd7,
      CMD_BST   = 4'd8
   } cmd_e;

   typedef enum logic [3:0] {
      ST_IDLE     = 4'd0,
      ST_OPENING  = 4'd1,
      ST_ACTIVE   = 4'd2,
      ST_READ     = 4'd3,
      ST_WRITE    = 4'd4,
      ST_RD_AP    = 4'd5,
      ST_WR_AP    = 4'd6,
      ST_AP_CLOSE = 4'd7,
      ST_CLOSING  = 4'd8
   } bank_st_e;

endpackage

// File: rtl/ddr_cmd_decode.sv
module ddr_cmd_decode
   import ddr_chk_pkg::*;
(
   input  logic cs_n_i,
   input  logic ras_n_i,
   input  logic cas_n_i,
   input  logic we_n_i,
   output cmd_e cmd_o
);

   always_comb begin
      if (cs_n_i) begin
         cmd_o = CMD_DESEL;
      end else begin
         case ({ras_n_i, cas_n_i, we_n_i})
            3'b111:  cmd_o = CMD_NOP;
            3'b011:  cmd_o = CMD_ACT;
            3'b101:  cmd_o = CMD_RD;
            3'b100:  cmd_o = CMD_WR;
            3'b010:  cmd_o = CMD_PRE;
            3'b001:  cmd_o = CMD_REF;
            3'b000:  cmd_o = CMD_MRS;
            default: cmd_o = CMD_BST;
         endcase
      end
   end

endmodule

// File: rtl/ddr_cmd_rules.sv
module ddr_cmd_rules
   import ddr_chk_pkg::*;
#(
   parameter int NUM_BANKS      = 4,
   parameter bit PRE_IDLE_LEGAL = 1'b1,
   localparam int BA_W          = $clog2(NUM_BANKS)
) (
   input  cmd_e            cmd_i,
   input  logic [BA_W-1:0] ba_i,
   input  bank_st_e        st_i [NUM_BANKS],
   output logic            legal_o,
   output logic            all_idle_o
);

   logic     pre_idle_ok;
   logic     other_rd;
   logic     other_acc;
   bank_st_e tgt;

   // variant: precharge of an already idle bank accepted or rejected
   generate
      if (PRE_IDLE_LEGAL) begin : g_pre_idle_ok
         assign pre_idle_ok = 1'b1;
      end else begin : g_pre_idle_bad
         assign pre_idle_ok = 1'b0;
      end
   endgenerate

   always_comb begin
      tgt        = st_i[ba_i];
      all_idle_o = 1'b1;
      other_rd   = 1'b0;
      other_acc  = 1'b0;
      for (int b = 0; b < NUM_BANKS; b++) begin
         if (st_i[b] != ST_IDLE) all_idle_o = 1'b0;
         if (BA_W'(b) != ba_i) begin
            if (st_i[b] == ST_READ) other_rd = 1'b1;
            if (st_i[b] == ST_RD_AP || st_i[b] == ST_WR_AP) other_acc = 1'b1;
         end
      end
   end

   always_comb begin
      case (cmd_i)
         CMD_DESEL, CMD_NOP: legal_o = 1'b1;
         CMD_ACT:            legal_o = (tgt == ST_IDLE);
         CMD_RD:             legal_o = (tgt == ST_ACTIVE || tgt == ST_READ ||
                                        tgt == ST_WRITE) && !other_acc;
         CMD_WR:             legal_o = (tgt == ST_ACTIVE || tgt == ST_WRITE) &&
                                       !other_acc && !other_rd;
         CMD_PRE:            legal_o = (tgt == ST_ACTIVE || tgt == ST_READ ||
                                        tgt == ST_WRITE) ||
                                       (tgt == ST_IDLE && pre_idle_ok);
         CMD_REF, CMD_MRS:   legal_o = all_idle_o;
         CMD_BST:            legal_o = (tgt == ST_READ);
         default:            legal_o = 1'b0;
      endcase
   end

endmodule

// File: rtl/ddr_bank_seq.sv
module ddr_bank_seq
   import ddr_chk_pkg::*;
#(
   parameter int T_RCD     = 3,
   parameter int T_RP      = 2,
   parameter int T_WR      = 2,
   parameter int BURST_LEN = 4
) (
   input  logic     clk,
   input  logic     rst_n,
   input  logic     go_i,
   input  cmd_e     cmd_i,
   input  logic     ap_i,
   output bank_st_e st_o
);

   localparam int BEATS = BURST_LEN / 2;
   localparam int WRAP  = BEATS + T_WR;
   localparam int M1    = (T_RCD > T_RP) ? T_RCD : T_RP;
   localparam int MAXD  = (M1 > WRAP) ? M1 : WRAP;
   localparam int CW    = $clog2(MAXD + 1);

   bank_st_e st_q, st_d;
   logic [CW-1:0] cnt_q, cnt_d;

   always_comb begin
      st_d  = st_q;
      cnt_d = cnt_q;
      if (go_i) begin
         case (cmd_i)
            CMD_ACT: begin
               st_d  = ST_OPENING;
               cnt_d = CW'(T_RCD - 1);
            end
            CMD_RD: begin
               st_d  = ap_i ? ST_RD_AP : ST_READ;
               cnt_d = CW'(BEATS - 1);
            end
            CMD_WR: begin
               st_d  = ap_i ? ST_WR_AP : ST_WRITE;
               cnt_d = ap_i ? CW'(WRAP - 1) : CW'(BEATS - 1);
            end
            CMD_PRE: begin
               if (st_q != ST_IDLE) begin
                  st_d  = ST_CLOSING;
                  cnt_d = CW'(T_RP - 1);
               end
            end
            CMD_BST: st_d = ST_ACTIVE;
            default: ;
         endcase
      end else if (st_q != ST_IDLE && st_q != ST_ACTIVE) begin
         if (cnt_q != '0) begin
            cnt_d = cnt_q - CW'(1);
         end else begin
            case (st_q)
               ST_OPENING, ST_READ, ST_WRITE: st_d = ST_ACTIVE;
               ST_RD_AP, ST_WR_AP: begin
                  st_d  = ST_AP_CLOSE;
                  cnt_d = CW'(T_RP - 1);
               end
               default: st_d = ST_IDLE;
            endcase
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q  <= ST_IDLE;
         cnt_q <= '0;
      end else begin
         st_q  <= st_d;
         cnt_q <= cnt_d;
      end
   end

   assign st_o = st_q;

   assert_idle_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_IDLE && !go_i) |=> st_q == ST_IDLE);

   assert_act_opens_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (go_i && cmd_i == CMD_ACT) |=> st_q == ST_OPENING);

   assert_bst_returns_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (go_i && cmd_i == CMD_BST) |=> st_q == ST_ACTIVE);

   assert_ap_close_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_AP_CLOSE && !go_i && cnt_q == '0) |=> st_q == ST_IDLE);

endmodule

// File: rtl/ddr_bank_cmd_checker.sv
module ddr_bank_cmd_checker
   import ddr_chk_pkg::*;
#(
   parameter int NUM_BANKS      = 4,
   parameter int T_RCD          = 3,
   parameter int T_RP           = 2,
   parameter int T_WR           = 2,
   parameter int BURST_LEN      = 4,
   parameter bit PRE_IDLE_LEGAL = 1'b1,
   localparam int BA_W          = $clog2(NUM_BANKS)
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   cke_i,
   input  logic                   cs_n_i,
   input  logic                   ras_n_i,
   input  logic                   cas_n_i,
   input  logic                   we_n_i,
   input  logic [BA_W-1:0]        ba_i,
   input  logic                   ap_i,
   output logic                   illegal_o,
   output logic [3:0]             cmd_o,
   output logic [4*NUM_BANKS-1:0] bank_state_o
);

   generate
      if (NUM_BANKS < 2 || (NUM_BANKS & (NUM_BANKS - 1)) != 0) begin : g_bad_banks
         $error("NUM_BANKS must be a power of two of at least 2");
      end
      if (T_RCD < 1 || T_RP < 1 || T_WR < 1) begin : g_bad_timing
         $error("T_RCD, T_RP and T_WR must each be at least 1");
      end
      if (BURST_LEN != 2 && BURST_LEN != 4 && BURST_LEN != 8) begin : g_bad_bl
         $error("BURST_LEN must be 2, 4 or 8");
      end
   endgenerate

   cmd_e     cmd_dec;
   cmd_e     cmd_q;
   logic     cke_q;
   logic     eval;
   logic     legal;
   logic     all_idle;
   logic     illegal_q;
   logic     is_bank_cmd;
   bank_st_e bank_st [NUM_BANKS];

   ddr_cmd_decode u_dec (
      .cs_n_i  (cs_n_i),
      .ras_n_i (ras_n_i),
      .cas_n_i (cas_n_i),
      .we_n_i  (we_n_i),
      .cmd_o   (cmd_dec)
   );

   ddr_cmd_rules #(
      .NUM_BANKS      (NUM_BANKS),
      .PRE_IDLE_LEGAL (PRE_IDLE_LEGAL)
   ) u_rules (
      .cmd_i      (cmd_dec),
      .ba_i       (ba_i),
      .st_i       (bank_st),
      .legal_o    (legal),
      .all_idle_o (all_idle)
   );

   assign eval = cke_i && cke_q;

   always_comb begin
      case (cmd_dec)
         CMD_ACT, CMD_RD, CMD_WR, CMD_PRE, CMD_BST: is_bank_cmd = 1'b1;
         default:                                   is_bank_cmd = 1'b0;
      endcase
   end

   for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
      logic go;
      assign go = eval && legal && is_bank_cmd && (ba_i == BA_W'(g));

      ddr_bank_seq #(
         .T_RCD     (T_RCD),
         .T_RP      (T_RP),
         .T_WR      (T_WR),
         .BURST_LEN (BURST_LEN)
      ) u_seq (
         .clk   (clk),
         .rst_n (rst_n),
         .go_i  (go),
         .cmd_i (cmd_dec),
         .ap_i  (ap_i),
         .st_o  (bank_st[g])
      );

      assign bank_state_o[4*g +: 4] = bank_st[g];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cke_q     <= 1'b0;
         illegal_q <= 1'b0;
         cmd_q     <= CMD_DESEL;
      end else begin
         cke_q     <= cke_i;
         illegal_q <= eval && !legal;
         cmd_q     <= eval ? cmd_dec : CMD_DESEL;
      end
   end

   assign illegal_o = illegal_q;
   assign cmd_o     = cmd_q;

   assert_gated_quiet_R12: assert property (@(posedge clk) disable iff (!rst_n)
      !(cke_i && cke_q) |=> !illegal_o);

   assert_idle_cmds_clean_R2: assert property (@(posedge clk) disable iff (!rst_n)
      illegal_o |-> (cmd_q != CMD_DESEL && cmd_q != CMD_NOP));

   assert_global_cmd_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (!illegal_o && (cmd_q == CMD_REF || cmd_q == CMD_MRS)) |-> $past(all_idle));

endmodule

// File: tb/ddr_bank_cmd_checker_tb.sv
`timescale 1ns/1ps
module ddr_bank_cmd_checker_tb_top;

   localparam int NB = 4, TRCD = 3, TRP = 2, TWR = 2, BL = 4, HB = BL / 2;
   localparam int C_DESEL = 0, C_NOP = 1, C_ACT = 2, C_RD = 3, C_WR = 4,
                  C_PRE = 5, C_REF = 6, C_MRS = 7, C_BST = 8;
   localparam int S_IDLE = 0, S_OPEN = 1, S_ACT = 2, S_READ = 3, S_WRITE = 4,
                  S_RDA = 5, S_WRA = 6, S_APC = 7, S_CLOSE = 8;

   logic clk = 1'b0;
   always #2.5 clk = ~clk;

   logic rst_n, cke, cs_n, ras_n, cas_n, we_n, ap;
   logic [1:0] ba;
   logic illegal_o;
   logic [3:0] cmd_o;
   logic [4*NB-1:0] bank_state_o;

   ddr_bank_cmd_checker #(
      .NUM_BANKS (NB), .T_RCD (TRCD), .T_RP (TRP), .T_WR (TWR),
      .BURST_LEN (BL), .PRE_IDLE_LEGAL (1'b1)
   ) dut_i (
      .clk (clk), .rst_n (rst_n), .cke_i (cke), .cs_n_i (cs_n),
      .ras_n_i (ras_n), .cas_n_i (cas_n), .we_n_i (we_n), .ba_i (ba),
      .ap_i (ap), .illegal_o (illegal_o), .cmd_o (cmd_o),
      .bank_state_o (bank_state_o)
   );

   int vectors = 0, errors = 0;
   bit done = 1'b0;
   int m_st [NB];
   int m_rem [NB];
   bit m_ckeq = 1'b0;
   bit e_ill = 1'b0;
   int e_cmd = 0;
   logic [31:0] rs = 32'h1234_5678;

   function automatic int rnd();
      rs = rs ^ (rs << 13);
      rs = rs ^ (rs >> 17);
      rs = rs ^ (rs << 5);
      return int'(rs[30:0]);
   endfunction

   function automatic logic [3:0] pins(int c);
      case (c)
         C_NOP:   return 4'b0111;
         C_ACT:   return 4'b0011;
         C_RD:    return 4'b0101;
         C_WR:    return 4'b0100;
         C_PRE:   return 4'b0010;
         C_REF:   return 4'b0001;
         C_MRS:   return 4'b0000;
         C_BST:   return 4'b0110;
         default: return 4'b1111;
      endcase
   endfunction

   function automatic string tagof(int c);
      case (c)
         C_ACT:        return "R3";
         C_RD, C_WR:   return "R4";
         C_PRE:        return "R5";
         C_REF, C_MRS: return "R9";
         C_BST:        return "R10";
         default:      return "R2";
      endcase
   endfunction

   // reference rules built from the requirement list
   function automatic bit m_ok(int c, int b);
      bit rd_else = 0, acc_else = 0, idle_all = 1;
      int t = m_st[b];
      for (int k = 0; k < NB; k++) begin
         if (m_st[k] != S_IDLE) idle_all = 0;
         if (k != b && m_st[k] == S_READ) rd_else = 1;
         if (k != b && (m_st[k] == S_RDA || m_st[k] == S_WRA)) acc_else = 1;
      end
      case (c)
         C_DESEL, C_NOP: return 1;
         C_ACT:          return t == S_IDLE;
         C_RD:           return (t == S_ACT || t == S_READ || t == S_WRITE) && !acc_else;
         C_WR:           return (t == S_ACT || t == S_WRITE) && !acc_else && !rd_else;
         C_PRE:          return t == S_ACT || t == S_READ || t == S_WRITE || t == S_IDLE;
         C_REF, C_MRS:   return idle_all;
         C_BST:          return t == S_READ;
         default:        return 0;
      endcase
   endfunction

   task automatic m_tick(int k);
      if (m_st[k] != S_IDLE && m_st[k] != S_ACT) begin
         m_rem[k]--;
         if (m_rem[k] == 0) begin
            if (m_st[k] == S_RDA || m_st[k] == S_WRA) begin
               m_st[k] = S_APC; m_rem[k] = TRP;
            end else if (m_st[k] == S_APC || m_st[k] == S_CLOSE) m_st[k] = S_IDLE;
            else m_st[k] = S_ACT;
         end
      end
   endtask

   task automatic m_cmd(int k, int c, bit a);
      case (c)
         C_ACT: begin m_st[k] = S_OPEN; m_rem[k] = TRCD; end
         C_RD:  begin m_st[k] = a ? S_RDA : S_READ; m_rem[k] = HB; end
         C_WR:  begin m_st[k] = a ? S_WRA : S_WRITE; m_rem[k] = a ? HB + TWR : HB; end
         C_PRE: if (m_st[k] != S_IDLE) begin m_st[k] = S_CLOSE; m_rem[k] = TRP; end
         C_BST: m_st[k] = S_ACT;
         default: ;
      endcase
   endtask

   task automatic compare(string tag);
      vectors++;
      if (illegal_o !== e_ill) begin
         errors++;
         $display("FAIL %s illegal_o got %0b expected %0b", tag, illegal_o, e_ill);
      end
      if (cmd_o !== 4'(e_cmd)) begin
         errors++;
         $display("FAIL %s cmd_o got %0d expected %0d", tag, cmd_o, e_cmd);
      end
      for (int k = 0; k < NB; k++) begin
         if (bank_state_o[4*k +: 4] !== 4'(m_st[k])) begin
            errors++;
            $display("FAIL %s bank %0d state got %0d expected %0d",
                     tag, k, bank_state_o[4*k +: 4], m_st[k]);
         end
      end
   endtask

   // drive at a falling edge, predict, compare at the next falling edge
   task automatic apply(int c, int b, bit a, bit k, string tag);
      bit ev, ok, g;
      {cs_n, ras_n, cas_n, we_n} = pins(c);
      ba = 2'(b); ap = a; cke = k;
      ev = k && m_ckeq;
      ok = m_ok(c, b);
      e_ill = ev && !ok;
      e_cmd = ev ? c : C_DESEL;
      g = ev && ok && (c == C_ACT || c == C_RD || c == C_WR || c == C_PRE || c == C_BST);
      for (int q = 0; q < NB; q++) begin
         if (g && q == b) m_cmd(q, c, a);
         else m_tick(q);
      end
      m_ckeq = k;
      @(negedge clk);
      compare(tag);
   endtask

   task automatic idle(int n, string tag);
      for (int i = 0; i < n; i++) apply(C_NOP, 0, 0, 1, tag);
   endtask

   initial begin
      for (int k = 0; k < NB; k++) begin m_st[k] = S_IDLE; m_rem[k] = 0; end
      rst_n = 1'b0; cke = 1'b0; {cs_n, ras_n, cas_n, we_n} = 4'b1111; ba = '0; ap = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      compare("R13");                        // reset state
      apply(C_NOP, 0, 0, 1, "R12");          // previous cke low: not evaluated
      apply(C_DESEL, 0, 0, 1, "R1");
      apply(C_MRS, 0, 0, 1, "R9");
      apply(C_REF, 1, 0, 1, "R9");
      apply(C_BST, 0, 0, 1, "R10");          // idle bank: illegal
      apply(C_PRE, 3, 0, 1, "R5");           // idle precharge accepted
      apply(C_ACT, 0, 0, 1, "R3");
      apply(C_ACT, 0, 0, 1, "R11");          // second activate rejected
      apply(C_RD, 0, 0, 1, "R4");            // still opening: rejected
      apply(C_PRE, 0, 0, 1, "R5");           // opening: rejected
      idle(2, "R3");
      apply(C_REF, 2, 0, 1, "R9");           // bank open: rejected
      apply(C_RD, 0, 0, 1, "R4");
      apply(C_WR, 0, 0, 1, "R4");            // same bank reading: rejected
      idle(2, "R4");
      apply(C_WR, 0, 0, 1, "R4");
      apply(C_RD, 0, 0, 1, "R4");            // read during own write
      apply(C_ACT, 1, 0, 1, "R6");
      idle(3, "R6");
      apply(C_RD, 1, 0, 1, "R6");
      apply(C_WR, 0, 0, 1, "R6");            // other bank reading: rejected
      idle(2, "R6");
      apply(C_WR, 0, 0, 1, "R6");
      apply(C_RD, 1, 0, 1, "R6");            // other bank writing: allowed
      apply(C_BST, 1, 0, 1, "R10");
      apply(C_BST, 1, 0, 1, "R10");          // no longer reading: rejected
      idle(2, "R2");
      apply(C_RD, 0, 1, 1, "R7");            // read with auto-precharge
      apply(C_WR, 1, 0, 1, "R8");            // other bank in access phase
      apply(C_RD, 1, 0, 1, "R8");
      apply(C_ACT, 2, 0, 1, "R8");
      apply(C_PRE, 1, 0, 1, "R8");
      apply(C_PRE, 0, 0, 1, "R5");           // bank in AP close: rejected
      idle(5, "R7");
      apply(C_ACT, 0, 0, 1, "R3");
      idle(3, "R7");
      apply(C_WR, 2, 1, 1, "R7");            // write with auto-precharge
      apply(C_RD, 0, 0, 1, "R8");
      idle(3, "R8");
      apply(C_RD, 0, 0, 1, "R8");            // other bank in AP close: allowed
      idle(4, "R7");
      apply(C_PRE, 0, 0, 1, "R5");
      idle(3, "R5");
      apply(C_ACT, 3, 0, 0, "R12");          // cke low
      apply(C_ACT, 3, 0, 1, "R12");          // cke was low
      apply(C_ACT, 3, 0, 1, "R12");
      apply(C_NOP, 0, 0, 1, "R2");
      apply(C_DESEL, 0, 0, 1, "R2");
      idle(3, "R2");
      apply(C_PRE, 3, 0, 1, "R5");
      idle(3, "R9");
      apply(C_REF, 0, 0, 1, "R9");
      apply(C_MRS, 1, 0, 1, "R1");
      // steered sweep over commands, banks and the auto-precharge bit
      for (int i = 0; i < 6000; i++) begin
         int c, b;
         bit a, k;
         c = C_NOP; b = 0;
         k = (rnd() % 32) != 0;
         for (int t = 0; t < 6; t++) begin
            c = rnd() % 9;
            b = rnd() % NB;
            if (m_ok(c, b)) break;
         end
         a = (rnd() % 2) == 1;
         apply(c, b, a, k, tagof(c));
      end
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog expired, R1 sequence incomplete");
         $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
         $finish;
      end
   end

endmodule